// File: doc/BRIEF.md
# Activity Event Detector with Idle Timer

This block watches for signs that the system is busy and restarts an idle timer each time it sees one. When the timer runs out, the block asks for a slower CPU clock, for a system-management interrupt, or for both. Each of these requests has its own enable input. The block only produces these requests. Dividing the clock and servicing the interrupt are done elsewhere.

There are eight activity sources. Six of them are classes of interrupt lines. The block sees interrupt activity only through interrupt-acknowledge cycles, which carry the number of the acknowledged line. The seventh source is the level of the maskable interrupt request. The eighth is a rising edge on the non-maskable interrupt pin. An 8-bit enable mask selects which sources count. In any clock, the OR of the enabled detections forms a one-clock event. The event has one effect only: it reloads the timer from the reload input.

Top module: `idle_activity_monitor`

## Requirements
- R1: A clock edge with `rst_n` low clears `activity_evt`, `slow_clk_req` and `smi_req`, clears the expired state and loads the timer from `reload_val`.
- R2: A clock with `ack_valid` high is an acknowledge cycle for line `ack_irq`. Line 0 maps to class bit 0, line 1 to bit 1, lines 3/4/5/7 to bit 2, lines 6/14 to bit 3, lines 9/13 to bit 4, and lines 8/10/11/12/15 to bit 5. Line 2 belongs to no class. `ack_irq` is ignored while `ack_valid` is low.
- R3: A source whose bit in `enable_mask` is 0 never causes an event.
- R4: With mask bit 6 set, every clock in which `intr` is high is a detection.
- R5: With mask bit 7 set, a clock in which `nmi` is high and was low in the previous clock is a detection. Holding `nmi` high gives only one detection. The previous value counts as low just after reset.
- R6: `activity_evt` is high in the clock after the one in which any enabled detection occurred. Several detections in the same clock give a single event.
- R7: After the timer is loaded with value V and no event occurs, the timer expires at the (V+1)-th clock edge after the load. A value of 0 expires at the next edge.
- R8: `slow_clk_req` is high while the timer is expired and `slow_en` is high. It falls at the same edge at which `activity_evt` rises.
- R9: `smi_req` is a one-clock pulse at the expiry edge, issued only if `smi_en` is high at that edge. It does not repeat until the timer has been reloaded and has expired again.
- R10: Every event reloads the timer from `reload_val` and clears the expired state, so counting starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_valid | input | 1 | Interrupt-acknowledge cycle in this clock |
| ack_irq | input | 4 | Line number being acknowledged |
| intr | input | 1 | Maskable interrupt request level |
| nmi | input | 1 | Non-maskable interrupt pin |
| enable_mask | input | 8 | Per-source enable, bits 0-5 classes, 6 intr, 7 nmi |
| reload_val | input | TIMER_W | Idle timer reload value |
| slow_en | input | 1 | Allow the slow-clock request on expiry |
| smi_en | input | 1 | Allow the SMI request on expiry |
| activity_evt | output | 1 | One-clock activity event |
| slow_clk_req | output | 1 | Slow-clock request while idle |
| smi_req | output | 1 | One-clock SMI request at expiry |

## Verification
The bench sets `TIMER_W` to 6. With this width, reload values of 0, 3 and 5 expire within a few clocks, so the bench can step through many expiry and reload cycles. The bench sends acknowledge cycles for every one of the 16 line numbers, once with all classes enabled and once with single classes disabled. It holds `intr` and `nmi` high over several clocks to show level detection and edge detection side by side. It also produces expiries with each request enable off, to check the gating.

// File: rtl/iam_pkg.sv
// Package: shared constants and the line-to-class map for the idle activity monitor.
// Assumes acknowledged line numbers are 0..15; any other value maps to no class.
package iam_pkg;
    localparam int CLS_COUNT = 6;              // interrupt activity classes
    localparam int SRC_COUNT = CLS_COUNT + 2;  // classes + intr level + nmi edge
    localparam int INTR_BIT  = CLS_COUNT;
    localparam int NMI_BIT   = CLS_COUNT + 1;

    // Returns the class index of a line number, or -1 when it has no class.
    function automatic int irq_class(input int irq);
        case (irq)
            0:               return 0;
            1:               return 1;
            3, 4, 5, 7:      return 2;
            6, 14:           return 3;
            9, 13:           return 4;
            8, 10, 11, 12, 15: return 5;
            default:         return -1;
        endcase
    endfunction
endpackage

// File: rtl/iam_irq_classifier.sv
// Module: turns an acknowledge cycle into a one-hot class hit vector.
// Assumes ack_irq is only meaningful while ack_valid is high; purely combinational.
module iam_irq_classifier
    import iam_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic                 ack_valid,
    input  logic [IRQ_W-1:0]     ack_irq,
    output logic [CLS_COUNT-1:0] cls_hit
);
    int cls_idx;

    // Look up the class of the acknowledged line.
    always_comb begin
        cls_idx = irq_class(int'(ack_irq));
    end

    // One hit bit per class, live only during an acknowledge cycle.
    for (genvar c = 0; c < CLS_COUNT; c++) begin : g_cls
        assign cls_hit[c] = ack_valid && (cls_idx == c);
    end
endmodule

// File: rtl/iam_src_detect.sv
// Module: qualifies the eight activity sources with the enable mask and forms the event.
// Assumes intr and nmi are already synchronous to clk. evt_now is the same-clock OR,
// evt_q the registered one-clock event seen at the block output.
module iam_src_detect
    import iam_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CLS_COUNT-1:0] cls_hit,
    input  logic                 intr,
    input  logic                 nmi,
    input  logic [SRC_COUNT-1:0] enable_mask,
    output logic                 evt_now,
    output logic                 evt_q
);
    logic                 nmi_q;
    logic                 nmi_rise;
    logic [SRC_COUNT-1:0] src_vec;

    // Remember the previous nmi level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= nmi;
    end

    assign nmi_rise = nmi & ~nmi_q;
    assign src_vec  = {nmi_rise, intr, cls_hit};
    assign evt_now  = |(src_vec & enable_mask);

    // Register the event so the output is a clean one-clock pulse per detection clock.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_now;
    end

    AST_EVT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> ($past(enable_mask) != '0)); // R3
    AST_INTR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (intr && enable_mask[INTR_BIT]) |=> evt_q); // R4
    AST_ACK_CLASS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        ((cls_hit & enable_mask[CLS_COUNT-1:0]) != '0) |=> evt_q); // R6
endmodule

// File: rtl/iam_idle_timer.sv
// Module: down-counting idle timer with reload, expiry flag and request outputs.
// Assumes reload_now is the same-clock activity detection; reload has priority over counting.
module iam_idle_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reload_now,
    input  logic [TIMER_W-1:0] reload_val,
    input  logic               slow_en,
    input  logic               smi_en,
    output logic               slow_clk_req,
    output logic               smi_req
);
    logic [TIMER_W-1:0] count;
    logic               expired;

    // Count down, flag expiry once at zero, and pulse the SMI request at that edge.
    always_ff @(posedge clk) begin
        if (!rst_n || reload_now) begin
            count   <= reload_val;
            expired <= 1'b0;
            smi_req <= 1'b0;
        end else if (count != '0) begin
            count   <= count - 1'b1;
            smi_req <= 1'b0;
        end else if (!expired) begin
            expired <= 1'b1;
            smi_req <= smi_en;
        end else begin
            smi_req <= 1'b0;
        end
    end

    assign slow_clk_req = expired & slow_en;

    AST_SMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req); // R9
    AST_SMI_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> $rose(expired)); // R9
    AST_RELOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        reload_now |=> (!expired && count == $past(reload_val))); // R10
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !reload_now) |=> (count == '0)); // R7
endmodule

// File: rtl/idle_activity_monitor.sv
// Module: top of the activity event detector and idle timer.
// Assumes all inputs are synchronous to clk; reset is synchronous and active low.
module idle_activity_monitor
    import iam_pkg::*;
#(
    parameter int TIMER_W = 16,
    parameter int IRQ_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_valid,
    input  logic [IRQ_W-1:0]   ack_irq,
    input  logic               intr,
    input  logic               nmi,
    input  logic [7:0]         enable_mask,
    input  logic [TIMER_W-1:0] reload_val,
    input  logic               slow_en,
    input  logic               smi_en,
    output logic               activity_evt,
    output logic               slow_clk_req,
    output logic               smi_req
);
    logic [CLS_COUNT-1:0] cls_hit;
    logic                 evt_now;

    iam_irq_classifier #(.IRQ_W(IRQ_W)) u_cls (
        .ack_valid (ack_valid),
        .ack_irq   (ack_irq),
        .cls_hit   (cls_hit)
    );

    iam_src_detect u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .cls_hit     (cls_hit),
        .intr        (intr),
        .nmi         (nmi),
        .enable_mask (enable_mask),
        .evt_now     (evt_now),
        .evt_q       (activity_evt)
    );

    iam_idle_timer #(.TIMER_W(TIMER_W)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_now   (evt_now),
        .reload_val   (reload_val),
        .slow_en      (slow_en),
        .smi_en       (smi_en),
        .slow_clk_req (slow_clk_req),
        .smi_req      (smi_req)
    );

    AST_EVT_DROPS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        activity_evt |-> !slow_clk_req); // R8
endmodule

// File: tb/test_idle_activity_monitor.sv
// Scoreboard bench: a reference model derived from the requirements pushes expected
// outputs each clock; a monitor pops and compares at the falling edge.
module test_idle_activity_monitor;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ack_valid = 1'b0;
    logic [3:0]    ack_irq = '0;
    logic          intr = 1'b0;
    logic          nmi = 1'b0;
    logic [7:0]    enable_mask = '0;
    logic [TW-1:0] reload_val = 6'd5;
    logic          slow_en = 1'b1;
    logic          smi_en = 1'b1;
    logic          activity_evt, slow_clk_req, smi_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    string phase = "R1 reset";

    typedef struct {
        logic  evt;
        logic  exp;
        logic  smi;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    idle_activity_monitor #(.TIMER_W(TW), .IRQ_W(4)) i_idle_activity_monitor (
        .clk, .rst_n, .ack_valid, .ack_irq, .intr, .nmi, .enable_mask,
        .reload_val, .slow_en, .smi_en, .activity_evt, .slow_clk_req, .smi_req
    );

    // Reference model state.
    int      m_cnt = 0;
    logic    m_exp = 1'b0;
    logic    m_nmi_prev = 1'b0;

    function automatic int cls_of(input int irq);
        if (irq == 0) return 0;
        if (irq == 1) return 1;
        if (irq == 3 || irq == 4 || irq == 5 || irq == 7) return 2;
        if (irq == 6 || irq == 14) return 3;
        if (irq == 9 || irq == 13) return 4;
        if (irq == 8 || irq == 10 || irq == 11 || irq == 12 || irq == 15) return 5;
        return -1;
    endfunction

    // Driver side of the scoreboard: predict outputs at each edge and push them.
    always @(posedge clk) begin
        exp_t it;
        logic det;
        int   c;
        it.tag = phase;
        it.smi = 1'b0;
        if (!rst_n) begin
            m_cnt = int'(reload_val);
            m_exp = 1'b0;
            m_nmi_prev = 1'b0;
            it.evt = 1'b0;
        end else begin
            det = 1'b0;
            c = cls_of(int'(ack_irq));
            if (ack_valid && c >= 0 && enable_mask[c]) det = 1'b1;
            if (intr && enable_mask[6]) det = 1'b1;
            if (nmi && !m_nmi_prev && enable_mask[7]) det = 1'b1;
            m_nmi_prev = nmi;
            it.evt = det;
            if (det) begin
                m_cnt = int'(reload_val);
                m_exp = 1'b0;
            end else if (m_cnt != 0) begin
                m_cnt = m_cnt - 1;
            end else if (!m_exp) begin
                m_exp = 1'b1;
                it.smi = smi_en;
            end
        end
        it.exp = m_exp;
        sb.push_back(it);
    end

    task automatic chk(input string tag, input string what, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Monitor side: pop and compare away from the active edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            chk({it.tag, " R6"}, "activity_evt", activity_evt, it.evt);
            chk({it.tag, " R8"}, "slow_clk_req", slow_clk_req, it.exp & slow_en);
            chk({it.tag, " R9"}, "smi_req", smi_req, it.smi);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic ack(input int irq);
        ack_valid = 1'b1;
        ack_irq = 4'(irq);
        cyc(1);
        ack_valid = 1'b0;
        cyc(2);
    endtask

    initial begin
        phase = "R1 reset";
        cyc(3);
        rst_n = 1'b1;
        phase = "R7 expiry from reload 5";
        cyc(10);
        phase = "R2 class map all enabled";
        enable_mask = 8'h3F;
        for (int i = 0; i < 16; i++) ack(i);
        phase = "R2 ack_valid low ignored";
        ack_irq = 4'd1;
        cyc(8);
        phase = "R3 disabled class ignored";
        for (int b = 0; b < 6; b++) begin
            enable_mask = 8'h3F & ~(8'(1) << b);
            for (int i = 0; i < 16; i++) ack(i);
        end
        phase = "R3 all masked";
        enable_mask = 8'h00;
        intr = 1'b1; nmi = 1'b1;
        cyc(8);
        intr = 1'b0; nmi = 1'b0;
        cyc(2);
        phase = "R4 intr level";
        enable_mask = 8'h40;
        intr = 1'b1;
        cyc(4);
        intr = 1'b0;
        cyc(9);
        phase = "R5 nmi edge";
        enable_mask = 8'h80;
        nmi = 1'b1;
        cyc(5);
        nmi = 1'b0;
        cyc(2);
        nmi = 1'b1;
        cyc(1);
        nmi = 1'b0;
        cyc(9);
        phase = "R6 simultaneous sources";
        enable_mask = 8'hFF;
        ack_valid = 1'b1; ack_irq = 4'd14; intr = 1'b1; nmi = 1'b1;
        cyc(1);
        ack_valid = 1'b0; intr = 1'b0; nmi = 1'b0;
        cyc(9);
        phase = "R9 smi disabled";
        smi_en = 1'b0;
        ack(0);
        cyc(9);
        phase = "R8 slow disabled then enabled";
        smi_en = 1'b1;
        slow_en = 1'b0;
        ack(1);
        cyc(9);
        slow_en = 1'b1;
        cyc(2);
        phase = "R10 reload restarts count";
        reload_val = 6'd3;
        ack(0);
        ack(0);
        cyc(1);
        ack(0);
        cyc(8);
        phase = "R7 reload zero";
        reload_val = 6'd0;
        ack(1);
        cyc(4);
        phase = "R1 reset mid run";
        reload_val = 6'd5;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        phase = "R7 after reset";
        cyc(9);
        done = 1'b1;
        cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule